// File: doc/BRIEF.md
# Slot-Masked TDM Serial Transmitter

This block transmits words on a time-division multiplexed serial line in network mode. A frame is split into a programmable number of word-long time slots. A mask holds one bit per slot and says whether the block drives the line in that slot. The serial line is modelled as a data bit `sd_out` and an output enable `sd_oe`. A pad outside the block turns that pair into a tri-state pin, so other transmitters can use the slots this block leaves free.

The bit clock and the frame sync come from outside. The bit clock's rising edge reaches the block as a one-cycle strobe `bit_tick` in the system clock domain. A rising frame sync starts slot 0. At every word boundary the block looks up the mask bit of the slot that is about to start. In an enabled slot it loads the held data word into the shift register and sends it MSB first. Software refills the held word after each enabled slot, using the empty flag or its interrupt. If software writes the dummy strobe instead, the slot is used up with the line undriven. If software writes nothing, the old word goes out again and a sticky underrun flag is raised.

Top module: `tdm_slot_tx`

## Requirements
- R1: A rising `fsync` sampled on a `bit_tick` starts slot 0 at once. After that, each slot lasts `cfg_wlen` ticks, and the slot number wraps from `cfg_slots`-1 to 0.
- R2: In a slot whose `slot_mask` bit is 0, `sd_oe` is low for the whole slot. Such a slot leaves `tde`, `unf` and any pending write unchanged.
- R3: In a slot whose mask bit is 1 and for which the last write since the previous enabled boundary was `tx_wr`, that written word is sent with `sd_oe` high for the whole slot.
- R4: If the last such write was `dummy_wr`, the enabled slot is used up and `sd_oe` stays low for the whole slot.
- R5: `tde` is set in the cycle after each enabled-slot boundary. Either `tx_wr` or `dummy_wr` clears it in the following cycle. `irq` equals `tde` AND `irq_en`.
- R6: If neither write came before an enabled slot, `unf` is set and the last written word is sent again with `sd_oe` high. `unf` stays set until a `unf_clr` pulse. A new underrun in the same cycle as `unf_clr` wins.
- R7: In a driven slot, bit k of the slot (k = 0 first) on `sd_out` is bit `cfg_wlen`-1-k of the word. Only the low `cfg_wlen` bits of `tx_wdata` are used. `sd_out` changes one cycle after each `bit_tick` and is 0 while `sd_oe` is low.
- R8: Until the first rising `fsync` after reset, `sd_oe` stays low.
- R9: After reset, `sd_oe`, `sd_out`, `tde`, `unf` and `irq` are all 0.
- R10: A write in the same cycle as a boundary applies to the slot after the one starting. If `tx_wr` and `dummy_wr` occur together, `tx_wr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe marking a bit-clock rising edge |
| fsync | input | 1 | Frame sync level, sampled on `bit_tick` |
| cfg_wlen | input | 5 | Word length in bits, 2 to 16 |
| cfg_slots | input | 6 | Slots per frame, 1 to 32 |
| slot_mask | input | 32 | Per-slot enable, bit n for slot n |
| irq_en | input | 1 | Enables `irq` from `tde` |
| tx_wr | input | 1 | Data write strobe |
| tx_wdata | input | 16 | Data word, right-aligned |
| dummy_wr | input | 1 | Dummy write strobe: use up the next enabled slot undriven |
| unf_clr | input | 1 | Clears the underrun flag |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |
| tde | output | 1 | Transmit-empty flag |
| irq | output | 1 | Transmit interrupt request |
| unf | output | 1 | Sticky underrun flag |

## Verification
The hardest situation to reach from the ports is a software write that lands in the same cycle as a word boundary, in particular a data write and a dummy write together at that moment. Such a write must be credited to the following slot. In one stimulus phase both write strobes fire on a large share of the cycles, so they regularly coincide with boundaries, with each other and with underrun clears. Other phases starve the block of writes so that underruns with stale data occur, or supply only dummy writes.

// File: rtl/tdm_tx_pkg.sv
// Shared types for the slot-masked TDM transmitter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package tdm_tx_pkg;

    // What software supplied for the next enabled slot.
    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_DATA  = 2'd1,
        PEND_DUMMY = 2'd2
    } pend_t;

endpackage

// File: rtl/tdm_slot_timer.sv
// Slot timer: tracks the bit position within a word and the slot number
// within a frame. It flags a word boundary and names the slot that starts
// there. A rising frame sync forces slot 0.
// Assumes cfg_wlen in [2, MAX_WORD] and cfg_slots in [1, MAX_SLOTS], held
// constant while out of reset.
module tdm_slot_timer #(
    parameter int MAX_WORD  = 16,
    parameter int MAX_SLOTS = 32,
    localparam int WLW = $clog2(MAX_WORD + 1),
    localparam int SLW = $clog2(MAX_SLOTS + 1),
    localparam int SIW = $clog2(MAX_SLOTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_tick,
    input  logic           fsync,
    input  logic [WLW-1:0] cfg_wlen,
    input  logic [SLW-1:0] cfg_slots,
    output logic           boundary,
    output logic [SIW-1:0] next_slot
);

    logic           fs_q;
    logic           framed_q;
    logic [WLW-1:0] bit_cnt_q;
    logic [SIW-1:0] slot_q;
    logic           fs_rise;
    logic           last_bit;
    logic           last_slot;

    // Detect a frame start and the last bit of the current word.
    always_comb begin
        fs_rise   = bit_tick & fsync & ~fs_q;
        last_bit  = (bit_cnt_q == cfg_wlen - WLW'(1));
        last_slot = ({1'b0, slot_q} == cfg_slots - SLW'(1));
        boundary  = fs_rise | (bit_tick & framed_q & last_bit);
        if (fs_rise || last_slot) next_slot = '0;
        else                      next_slot = slot_q + SIW'(1);
    end

    // Advance the bit and slot counters on bit-clock ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q      <= 1'b0;
            framed_q  <= 1'b0;
            bit_cnt_q <= '0;
            slot_q    <= '0;
        end else begin
            if (bit_tick) fs_q <= fsync;
            if (boundary) begin
                framed_q  <= 1'b1;
                bit_cnt_q <= '0;
                slot_q    <= next_slot;
            end else if (bit_tick && framed_q) begin
                bit_cnt_q <= bit_cnt_q + WLW'(1);
            end
        end
    end

    // R1: the bit counter never passes the word length once framed.
    p_bitcnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        framed_q |-> (bit_cnt_q < cfg_wlen));

    // R1: the slot number stays below the programmed slot count.
    p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        framed_q |-> ({1'b0, slot_q} < cfg_slots));

    // R1: a rising frame sync always lands on slot 0 with a fresh word.
    p_fsync_slot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && fsync && !fs_q) |=> (slot_q == '0 && bit_cnt_q == '0));

endmodule

// File: rtl/tdm_tx_holding.sv
// Holding stage: keeps the software data word and records what was written
// since the last enabled boundary. It owns the empty and underrun flags.
// Assumes take pulses only on boundaries of enabled slots. Writes in the
// same cycle as take count toward the following slot.
module tdm_tx_holding
    import tdm_tx_pkg::*;
#(
    parameter int MAX_WORD = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                tx_wr,
    input  logic [MAX_WORD-1:0] tx_wdata,
    input  logic                dummy_wr,
    input  logic                unf_clr,
    output logic [MAX_WORD-1:0] hold_word,
    output pend_t               pend,
    output logic                tde,
    output logic                unf
);

    logic [MAX_WORD-1:0] word_q;
    pend_t               pend_q;
    logic                tde_q;
    logic                unf_q;

    // Consume the pending write at an enabled boundary, then apply new writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            pend_q <= PEND_NONE;
            tde_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            if (take) begin
                tde_q  <= 1'b1;
                pend_q <= PEND_NONE;
            end
            if (take && pend_q == PEND_NONE) unf_q <= 1'b1;
            else if (unf_clr)                unf_q <= 1'b0;
            if (tx_wr) begin
                word_q <= tx_wdata;
                pend_q <= PEND_DATA;
                tde_q  <= 1'b0;
            end else if (dummy_wr) begin
                pend_q <= PEND_DUMMY;
                tde_q  <= 1'b0;
            end
        end
    end

    assign hold_word = word_q;
    assign pend      = pend_q;
    assign tde       = tde_q;
    assign unf       = unf_q;

    // R5: an enabled boundary with no write beside it leaves the flag set.
    p_tde_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !tx_wr && !dummy_wr) |=> tde_q);

    // R5: either write clears the empty flag.
    p_tde_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr || dummy_wr) |=> !tde_q);

    // R6: underrun stays set until it is cleared.
    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !unf_clr) |=> unf_q);

    // R6: an unfed enabled slot raises underrun.
    p_unf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pend_q == PEND_NONE) |=> unf_q);

    // R2: outside enabled boundaries and writes, the pending state holds.
    p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !tx_wr && !dummy_wr) |=> $stable(pend_q) && $stable(tde_q));

endmodule

// File: rtl/tdm_tx_shifter.sv
// Output shifter: at each boundary it either loads the held word,
// left-aligned, and sets the output enable, or leaves the line undriven.
// Between boundaries it shifts one bit per tick, MSB first.
// Assumes cfg_wlen in [2, MAX_WORD].
module tdm_tx_shifter
    import tdm_tx_pkg::*;
#(
    parameter int MAX_WORD = 16,
    localparam int WLW = $clog2(MAX_WORD + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                boundary,
    input  logic                take,
    input  pend_t               pend,
    input  logic [MAX_WORD-1:0] hold_word,
    input  logic [WLW-1:0]      cfg_wlen,
    output logic                sd_out,
    output logic                sd_oe
);

    localparam logic [WLW-1:0] MW = WLW'(MAX_WORD);

    logic [MAX_WORD-1:0] sh_q;
    logic                oe_q;
    logic [WLW-1:0]      pad;

    // Distance to shift a right-aligned word up to the MSB.
    always_comb pad = MW - cfg_wlen;

    // Load at boundaries, otherwise shift on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            oe_q <= 1'b0;
        end else if (boundary) begin
            if (take) begin
                sh_q <= hold_word << pad;
                oe_q <= (pend != PEND_DUMMY);
            end else begin
                oe_q <= 1'b0;
            end
        end else if (bit_tick) begin
            sh_q <= sh_q << 1;
        end
    end

    assign sd_out = oe_q & sh_q[MAX_WORD-1];
    assign sd_oe  = oe_q;

    // R2: the enable only changes at word boundaries.
    p_oe_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(oe_q));

    // R4: a dummy-fed enabled slot stays undriven.
    p_dummy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pend == PEND_DUMMY) |=> !oe_q);

    // R7: the data line is quiet whenever the enable is low.
    p_quiet_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

endmodule

// File: rtl/tdm_slot_tx.sv
// Top of the slot-masked TDM transmitter. It joins the slot timer, the
// mask lookup, the holding stage and the output shifter.
// Assumes bit_tick is a one-cycle strobe per bit-clock rising edge, the
// configuration is static out of reset, and an external pad turns
// sd_out/sd_oe into a tri-state pin.
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int MAX_WORD  = 16,
    parameter int MAX_SLOTS = 32,
    localparam int WLW = $clog2(MAX_WORD + 1),
    localparam int SLW = $clog2(MAX_SLOTS + 1),
    localparam int SIW = $clog2(MAX_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 fsync,
    input  logic [WLW-1:0]       cfg_wlen,
    input  logic [SLW-1:0]       cfg_slots,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic                 irq_en,
    input  logic                 tx_wr,
    input  logic [MAX_WORD-1:0]  tx_wdata,
    input  logic                 dummy_wr,
    input  logic                 unf_clr,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 tde,
    output logic                 irq,
    output logic                 unf
);

    logic                boundary;
    logic [SIW-1:0]      next_slot;
    logic                take;
    logic [MAX_WORD-1:0] hold_word;
    pend_t               pend;

    tdm_slot_timer #(.MAX_WORD(MAX_WORD), .MAX_SLOTS(MAX_SLOTS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .fsync     (fsync),
        .cfg_wlen  (cfg_wlen),
        .cfg_slots (cfg_slots),
        .boundary  (boundary),
        .next_slot (next_slot)
    );

    // Mask lookup: the starting slot is driven only if its bit is set.
    always_comb take = boundary & slot_mask[next_slot];

    tdm_tx_holding #(.MAX_WORD(MAX_WORD)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .tx_wr     (tx_wr),
        .tx_wdata  (tx_wdata),
        .dummy_wr  (dummy_wr),
        .unf_clr   (unf_clr),
        .hold_word (hold_word),
        .pend      (pend),
        .tde       (tde),
        .unf       (unf)
    );

    tdm_tx_shifter #(.MAX_WORD(MAX_WORD)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .boundary  (boundary),
        .take      (take),
        .pend      (pend),
        .hold_word (hold_word),
        .cfg_wlen  (cfg_wlen),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe)
    );

    // Interrupt request follows the empty flag when enabled.
    always_comb irq = tde & irq_en;

    // R2: a masked slot starts undriven.
    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !slot_mask[next_slot]) |=> !sd_oe);

    // R3: a data-fed enabled slot starts driven.
    p_data_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pend == PEND_DATA) |=> sd_oe);

    // R6: an unfed enabled slot is still driven with the stale word.
    p_stale_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pend == PEND_NONE) |=> sd_oe);

endmodule

// File: tb/tdm_slot_tx_tb.sv
// Bench: random writes over several frame configurations, checked cycle
// by cycle against a behavioural model built from the requirements.
module tdm_slot_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, fsync = 1'b0, irq_en = 1'b0;
    logic        tx_wr = 1'b0, dummy_wr = 1'b0, unf_clr = 1'b0;
    logic [4:0]  cfg_wlen = 5'd8;
    logic [5:0]  cfg_slots = 6'd5;
    logic [31:0] slot_mask = '0;
    logic [15:0] tx_wdata = '0;
    logic        sd_out, sd_oe, tde, irq, unf;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    // Model state
    bit          m_fsq, m_framed, m_oe, m_tde, m_unf;
    int          m_bcnt, m_slot, m_pos, m_pend;
    logic [15:0] m_txreg, m_word;

    // Stimulus generator state
    int g_div, g_bit, g_lead;

    tdm_slot_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
        .cfg_wlen(cfg_wlen), .cfg_slots(cfg_slots), .slot_mask(slot_mask),
        .irq_en(irq_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .dummy_wr(dummy_wr), .unf_clr(unf_clr), .sd_out(sd_out),
        .sd_oe(sd_oe), .tde(tde), .irq(irq), .unf(unf)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit exp_bit(logic [15:0] w, int wl, int pos);
        return w[wl - 1 - pos];
    endfunction

    function automatic int step_slot(bit rise, int cur, int ns);
        if (rise || cur == ns - 1) return 0;
        return cur + 1;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_fsq = 0; m_framed = 0; m_oe = 0; m_tde = 0; m_unf = 0;
        m_bcnt = 0; m_slot = 0; m_pos = 0; m_pend = 0;
        m_txreg = '0; m_word = '0;
    endtask

    // Advance the model by one clock with the inputs currently applied.
    task automatic model_step();
        int  wl = int'(cfg_wlen);
        int  ns = int'(cfg_slots);
        bit  rise = bit_tick && fsync && !m_fsq;
        bit  bnd = rise || (bit_tick && m_framed && m_bcnt == wl - 1);
        int  nxt = step_slot(rise, m_slot, ns);
        bit  tk = bnd && slot_mask[nxt];
        bit  set_unf = 0;
        if (bit_tick) m_fsq = fsync;
        if (bnd) begin
            m_slot = nxt; m_bcnt = 0; m_framed = 1; m_pos = 0;
            if (tk) begin
                m_word = m_txreg;
                m_oe = (m_pend != 2);
                m_tde = 1;
                if (m_pend == 0) set_unf = 1;
                m_pend = 0;
            end else begin
                m_oe = 0;
            end
        end else if (bit_tick && m_framed) begin
            m_bcnt++; m_pos++;
        end
        if (set_unf) m_unf = 1;
        else if (unf_clr) m_unf = 0;
        if (tx_wr) begin
            m_txreg = tx_wdata; m_pend = 1; m_tde = 0;
        end else if (dummy_wr) begin
            m_pend = 2; m_tde = 0;
        end
    endtask

    task automatic compare();
        logic eo;
        eo = m_oe ? exp_bit(m_word, int'(cfg_wlen), m_pos) : 1'b0;
        if (!m_framed) chk("R8 enable before first frame", sd_oe, 1'b0);
        else if (m_oe) chk("R1/R3/R6 enable in driven slot", sd_oe, 1'b1);
        else chk("R1/R2/R4 enable in quiet slot", sd_oe, 1'b0);
        chk("R7 serial bit", sd_out, eo);
        chk("R5/R10 empty flag", tde, m_tde);
        chk("R5 interrupt", irq, m_tde & irq_en);
        chk("R6/R10 underrun flag", unf, m_unf);
    endtask

    task automatic run_phase(int wl, int ns, logic [31:0] mask, int pwr,
                             int pdm, int pclr, bit ien, bit prime, int cycles);
        @(negedge clk);
        rst_n = 1'b0; bit_tick = 0; fsync = 0; tx_wr = 0; dummy_wr = 0; unf_clr = 0;
        cfg_wlen = 5'(wl); cfg_slots = 6'(ns); slot_mask = mask; irq_en = ien;
        repeat (3) @(negedge clk);
        model_reset();
        // R9: everything quiet right after reset
        chk("R9 reset enable", sd_oe, 1'b0);
        chk("R9 reset data", sd_out, 1'b0);
        chk("R9 reset empty", tde, 1'b0);
        chk("R9 reset underrun", unf, 1'b0);
        chk("R9 reset irq", irq, 1'b0);
        rst_n = 1'b1;
        g_div = 0; g_bit = 0; g_lead = 4;
        for (int c = 0; c < cycles; c++) begin
            // drive this cycle's inputs
            bit_tick = (g_div == TICK_DIV - 1);
            fsync = (g_lead > 0) ? 1'b0 : (g_bit < wl);
            if (bit_tick) begin
                if (g_lead > 0) g_lead--;
                else g_bit = (g_bit + 1) % (wl * ns);
            end
            g_div = (g_div + 1) % TICK_DIV;
            tx_wr = (prime && c == 0) || (($urandom % 100) < pwr);
            tx_wdata = 16'($urandom);
            dummy_wr = ($urandom % 100) < pdm;
            unf_clr = ($urandom % 100) < pclr;
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        run_phase(8, 5, 32'h0000_0009, 5, 0, 3, 1'b1, 1'b1, 3000);   // sparse mask
        run_phase(16, 32, $urandom, 4, 1, 2, 1'b0, 1'b1, 6000);      // full width, 32 slots
        run_phase(2, 1, 32'h1, 30, 5, 3, 1'b1, 1'b0, 1500);          // shortest word, one slot
        run_phase(5, 3, 32'h5, 0, 0, 0, 1'b1, 1'b1, 1500);           // starved: R6 stale resend
        run_phase(12, 4, 32'hF, 0, 6, 2, 1'b1, 1'b0, 2000);          // dummy only: R4
        run_phase(7, 6, $urandom, 50, 20, 10, 1'b1, 1'b0, 2000);     // R10 collisions
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule